// File: doc/BRIEF.md
# Retriggerable Triggered PWM Timer

This block is one channel of a 16-bit timer that produces a pulse-width modulated waveform only after it has been started by a trigger. When the channel is enabled, the counter parks at all-ones and the PWM output stays low. A trigger starts the waveform. The trigger is either a one-cycle software strobe or a chosen edge on an external input that is synchronised inside the block. The trigger clears the counter to zero and drives the PWM output to its active level. After that the counter advances once for each count-enable strobe.

Two compare values shape the waveform. The period value sets the cycle length: the counter wraps after it has held that value, so one cycle is period+1 strobes. The duty value sets the active width: the output falls when the counter reaches it, so the output is high for duty strobes. Each compare value passes through a buffer that is reloaded only when the counter reloads to zero, so a write never produces a malformed cycle.

A trigger that arrives while the counter is running restarts the cycle from zero. Every accepted trigger also inverts a separate indicator output. The block gives one-cycle pulses on a period match and on a duty match.

Top module: `trig_pwm_timer`

## Requirements
- R1: With `enable_i` high and no trigger accepted since it rose, `count_o` holds all-ones and `pwm_o`, `tog_o`, `period_match_o` and `duty_match_o` stay low.
- R2: A trigger is accepted when `enable_i` is high and either `sw_trig_i` is high at a clock edge or the external input shows an edge of the kind selected by `edge_sel_i` (00 none, 01 rising, 10 falling, 11 both). The external input passes through two synchronising flops, so an edge driven before clock edge N reloads the counter at clock edge N+2.
- R3: An accepted trigger sets `count_o` to 0. After that the counter increments by one on each clock edge where `cnt_en_i` is high, and it holds its value when `cnt_en_i` is low.
- R4: A trigger accepted while the counter is running clears it to 0 in the same way, whatever its current value.
- R5: `tog_o` inverts on every accepted trigger and does not change otherwise while the channel is enabled.
- R6: When the counter equals the period buffer value and a count strobe arrives, the counter goes to 0 and `period_match_o` is high for exactly that one clock. A cycle therefore lasts period+1 strobes.
- R7: `pwm_o` is high while the counter is below the duty buffer value and low otherwise. It is therefore low for the whole cycle when duty is 0 and high for the whole cycle when duty is greater than period. `duty_match_o` is a one-clock pulse in the clock where the counter takes the duty value.
- R8: A value written through `period_we_i`/`period_i` or `duty_we_i`/`duty_i` takes effect only at the next reload of the counter to 0, whether that reload comes from a trigger or from a period wrap.
- R9: While `enable_i` is low, `count_o` is all-ones, every output is low from the next clock, and triggers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Channel enable |
| cnt_en_i | input | 1 | Count-enable strobe |
| period_we_i | input | 1 | Write strobe for the period value |
| period_i | input | 16 | Period compare value |
| duty_we_i | input | 1 | Write strobe for the duty value |
| duty_i | input | 16 | Duty compare value |
| sw_trig_i | input | 1 | Software trigger strobe |
| ext_trig_i | input | 1 | External trigger input (asynchronous) |
| edge_sel_i | input | 2 | External edge select: 00 none, 01 rise, 10 fall, 11 both |
| count_o | output | 16 | Counter value |
| pwm_o | output | 1 | PWM output |
| tog_o | output | 1 | Trigger indicator, toggles on each trigger |
| period_match_o | output | 1 | Period-match pulse |
| duty_match_o | output | 1 | Duty-match pulse |

## Verification
The bench sweeps every period from 0 to 6 against every duty from 0 to period+2, over three cycles each. This covers the zero-period case, which wraps on every strobe, as well as duty 0 and duty above period. A design with an off-by-one compare would stretch the cycle or the active width by a strobe. Directed cases cover the following. Mid-period retrigger: a design that ignored it would finish the old cycle. Gaps in the count strobe: a free-running counter would drift. A period write in mid-cycle: an unbuffered design would wrap early. External edges under each edge selection: a wrong synchroniser depth moves the reload by a clock. Disabling the channel: a design that left triggers active would restart the counter.

// File: rtl/trig_pwm_pkg.sv
package trig_pwm_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/trig_edge_det.sv
module trig_edge_det
  import trig_pwm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sig_i,
  input  logic [1:0] edge_sel_i,
  output logic       edge_o
);
  // SYNC_STAGES synchroniser flops plus one history flop for edge compare
  logic [SYNC_STAGES:0] sh_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], sig_i};
  end

  assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign fall = ~sh_q[SYNC_STAGES-1] & sh_q[SYNC_STAGES];

  always_comb begin
    unique case (edge_sel_e'(edge_sel_i))
      EDGE_RISE: edge_o = rise;
      EDGE_FALL: edge_o = fall;
      EDGE_BOTH: edge_o = rise | fall;
      default:   edge_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmp_shadow.sv
module cmp_shadow #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             period_we_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             duty_we_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] period_buf_o,
  output logic [CNT_W-1:0] duty_buf_o,
  output logic [CNT_W-1:0] duty_nxt_o
);
  logic [CNT_W-1:0] period_pend_q, duty_pend_q, period_nxt;

  // a write in the reload cycle is taken into the new cycle
  assign period_nxt = period_we_i ? period_i : period_pend_q;
  assign duty_nxt_o = duty_we_i   ? duty_i   : duty_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_pend_q <= '1;
      duty_pend_q   <= '0;
      period_buf_o  <= '1;
      duty_buf_o    <= '0;
    end else begin
      period_pend_q <= period_nxt;
      duty_pend_q   <= duty_nxt_o;
      if (load_i) begin
        period_buf_o <= period_nxt;
        duty_buf_o   <= duty_nxt_o;
      end
    end
  end
endmodule

// File: rtl/trig_pwm_timer.sv
module trig_pwm_timer #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             cnt_en_i,
  input  logic             period_we_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             duty_we_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             sw_trig_i,
  input  logic             ext_trig_i,
  input  logic [1:0]       edge_sel_i,
  output logic [CNT_W-1:0] count_o,
  output logic             pwm_o,
  output logic             tog_o,
  output logic             period_match_o,
  output logic             duty_match_o
);
  localparam logic [CNT_W-1:0] CNT_IDLE = '1;
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic             ext_edge, trig, wrap, load, running_q;
  logic [CNT_W-1:0] period_buf, duty_buf, duty_nxt, cnt_inc;

  trig_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sig_i      (ext_trig_i),
    .edge_sel_i (edge_sel_i),
    .edge_o     (ext_edge)
  );

  cmp_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .period_we_i  (period_we_i),
    .period_i     (period_i),
    .duty_we_i    (duty_we_i),
    .duty_i       (duty_i),
    .load_i       (load),
    .period_buf_o (period_buf),
    .duty_buf_o   (duty_buf),
    .duty_nxt_o   (duty_nxt)
  );

  assign trig    = enable_i & (sw_trig_i | ext_edge);
  assign wrap    = enable_i & running_q & cnt_en_i & (count_o == period_buf) & ~trig;
  assign load    = trig | wrap;
  assign cnt_inc = count_o + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o        <= CNT_IDLE;
      running_q      <= 1'b0;
      pwm_o          <= 1'b0;
      tog_o          <= 1'b0;
      period_match_o <= 1'b0;
      duty_match_o   <= 1'b0;
    end else if (!enable_i) begin
      count_o        <= CNT_IDLE;
      running_q      <= 1'b0;
      pwm_o          <= 1'b0;
      tog_o          <= 1'b0;
      period_match_o <= 1'b0;
      duty_match_o   <= 1'b0;
    end else begin
      period_match_o <= 1'b0;
      duty_match_o   <= 1'b0;
      if (load) begin
        count_o        <= CNT_ZERO;
        running_q      <= 1'b1;
        pwm_o          <= (duty_nxt != CNT_ZERO);
        duty_match_o   <= (duty_nxt == CNT_ZERO);
        period_match_o <= wrap;
        if (trig) tog_o <= ~tog_o;
      end else if (running_q && cnt_en_i) begin
        count_o <= cnt_inc;
        if (cnt_inc == duty_buf) begin
          pwm_o        <= 1'b0;
          duty_match_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/trig_pwm_timer_chk.sv
module trig_pwm_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             cnt_en_i,
  input logic             trig_i,
  input logic [CNT_W-1:0] count_o,
  input logic             pwm_o,
  input logic             tog_o,
  input logic             period_match_o,
  input logic             duty_match_o
);
  assert_idle_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == {CNT_W{1'b1}}) |-> !pwm_o);

  assert_hold_no_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !trig_i && !cnt_en_i) |=> $stable(count_o));

  assert_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> (count_o == '0));

  assert_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> (tog_o != $past(tog_o)));

  assert_toggle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !trig_i) |=> $stable(tog_o));

  assert_wrap_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_match_o |-> (count_o == '0));

  assert_duty_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_match_o |-> !pwm_o);

  assert_disabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> ((count_o == {CNT_W{1'b1}}) && !pwm_o && !tog_o
                   && !period_match_o && !duty_match_o));
endmodule

bind trig_pwm_timer trig_pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .enable_i       (enable_i),
  .cnt_en_i       (cnt_en_i),
  .trig_i         (trig),
  .count_o        (count_o),
  .pwm_o          (pwm_o),
  .tog_o          (tog_o),
  .period_match_o (period_match_o),
  .duty_match_o   (duty_match_o)
);

// File: tb/trig_pwm_timer_tb.sv
module trig_pwm_timer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0, cnt_en_i = 1'b1;
  logic        period_we_i = 1'b0, duty_we_i = 1'b0;
  logic [15:0] period_i = '0, duty_i = '0;
  logic        sw_trig_i = 1'b0, ext_trig_i = 1'b0;
  logic [1:0]  edge_sel_i = 2'b00;
  logic [15:0] count_o;
  logic        pwm_o, tog_o, period_match_o, duty_match_o;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  trig_pwm_timer u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic wr(input int p, input int d);
    period_i = 16'(p); duty_i = 16'(d);
    period_we_i = 1'b1; duty_we_i = 1'b1;
    cyc();
    period_we_i = 1'b0; duty_we_i = 1'b0;
  endtask

  task automatic swt();
    sw_trig_i = 1'b1;
    cyc();
    sw_trig_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    vectors++; miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int c;
    repeat (3) cyc();
    chk("R9 reset count", int'(count_o), 65535);
    chk("R9 reset pwm", int'(pwm_o), 0);
    rst_ni = 1'b1;
    cyc();

    // sweep period x duty
    for (int p = 0; p <= 6; p++) begin
      for (int d = 0; d <= p + 2; d++) begin
        enable_i = 1'b0;
        wr(p, d);
        enable_i = 1'b1;
        cyc(); cyc();
        chk("R1 wait count", int'(count_o), 65535);
        chk("R1 wait pwm", int'(pwm_o), 0);
        chk("R1 wait tog", int'(tog_o), 0);
        swt();
        for (int k = 0; k < 3 * (p + 1); k++) begin
          int cc;
          cc = k % (p + 1);
          chk("R3 R6 count", int'(count_o), cc);
          chk("R7 pwm", int'(pwm_o), (cc < d) ? 1 : 0);
          chk("R6 period match", int'(period_match_o), (cc == 0 && k > 0) ? 1 : 0);
          chk("R7 duty match", int'(duty_match_o), (cc == d) ? 1 : 0);
          chk("R5 tog", int'(tog_o), 1);
          cyc();
        end
      end
    end

    // R3: count strobe gating
    enable_i = 1'b0; wr(9, 4); enable_i = 1'b1; cyc();
    swt();
    chk("R3 start", int'(count_o), 0);
    c = 0;
    for (int i = 0; i < 8; i++) begin
      cnt_en_i = i[0];
      cyc();
      if (i[0]) c++;
      chk("R3 gated count", int'(count_o), c);
    end
    chk("R7 pwm low at duty", int'(pwm_o), 0);
    cnt_en_i = 1'b1;

    // R4/R5: retrigger mid-period
    swt();
    chk("R4 retrigger count", int'(count_o), 0);
    chk("R4 retrigger pwm", int'(pwm_o), 1);
    chk("R5 tog back", int'(tog_o), 0);

    // R8: buffered period write
    cyc(); cyc();
    wr(3, 1);
    chk("R8 count at write", int'(count_o), 3);
    for (int j = 4; j <= 9; j++) begin
      cyc();
      chk("R8 old period kept", int'(count_o), j);
    end
    cyc();
    chk("R6 wrap count", int'(count_o), 0);
    chk("R6 wrap pulse", int'(period_match_o), 1);
    chk("R8 new duty pwm", int'(pwm_o), 1);
    cyc();
    chk("R8 new duty low", int'(pwm_o), 0);
    cyc(); cyc(); cyc();
    chk("R8 new period wrap", int'(count_o), 0);
    chk("R8 new period pulse", int'(period_match_o), 1);

    // R2: external trigger edges
    enable_i = 1'b0; wr(200, 100); enable_i = 1'b1;
    edge_sel_i = 2'b01; ext_trig_i = 1'b0;
    cyc();
    swt();
    repeat (4) cyc();
    chk("R2 pre count", int'(count_o), 4);
    ext_trig_i = 1'b1;
    cyc(); chk("R2 rise sync 1", int'(count_o), 5);
    cyc(); chk("R2 rise sync 2", int'(count_o), 6);
    cyc(); chk("R2 rise reload", int'(count_o), 0);
    chk("R2 rise tog", int'(tog_o), 0);
    ext_trig_i = 1'b0;
    repeat (3) cyc();
    chk("R2 fall ignored on rise sel", int'(count_o), 3);
    edge_sel_i = 2'b11;
    ext_trig_i = 1'b1;
    repeat (3) cyc();
    chk("R2 both rise", int'(count_o), 0);
    ext_trig_i = 1'b0;
    repeat (3) cyc();
    chk("R2 both fall", int'(count_o), 0);
    chk("R2 both tog", int'(tog_o), 0);
    edge_sel_i = 2'b10;
    ext_trig_i = 1'b1;
    repeat (3) cyc();
    chk("R2 rise ignored on fall sel", int'(count_o), 3);
    ext_trig_i = 1'b0;
    repeat (3) cyc();
    chk("R2 fall reload", int'(count_o), 0);
    edge_sel_i = 2'b00;
    ext_trig_i = 1'b1;
    repeat (3) cyc();
    ext_trig_i = 1'b0;
    repeat (3) cyc();
    chk("R2 none ignored", int'(count_o), 6);
    chk("R2 none tog", int'(tog_o), 1);

    // R9: disable
    enable_i = 1'b0;
    cyc();
    chk("R9 count idle", int'(count_o), 65535);
    chk("R9 pwm low", int'(pwm_o), 0);
    chk("R9 tog low", int'(tog_o), 0);
    sw_trig_i = 1'b1;
    cyc();
    sw_trig_i = 1'b0;
    chk("R9 trigger ignored", int'(count_o), 65535);
    chk("R9 tog stays", int'(tog_o), 0);

    finish_run();
  end
endmodule